// File: doc/BRIEF.md
# Split-Mode Timer Counter Value Register

This block holds the live count of a general-purpose timer and exposes it as one 32-bit value register that software can read and write. It runs in one of two widths. In wide mode two 16-bit halves form a single 32-bit counter; the low half is the primary timer and the upper half is the companion timer. In split mode only the low 16-bit half counts, and an 8-bit prescaler is attached to it.

The prescaler behaves differently depending on direction. When counting up, it is simply the top byte of a 24-bit up counter. When counting down, it is a true divider: it counts down from a reload value, and the 16-bit counter moves only when the prescaler wraps. Either direction can run one-shot, stopping at the terminal value, or periodic, reloading and continuing.

Writes to the value register are staged for one cycle before they reach the counter. In split mode they touch only the low 16 bits. Reads are registered on a read strobe, and in split mode they pack the prescaler into the word.

Top module: `tmr_value_reg`

## Requirements
- R1: After reset the low half, upper half and prescaler are all ones, the block is not active, and a wide-mode read returns 0xFFFFFFFF.
- R2: With `split_mode`=0, a read returns the upper half in bits 31:16 and the low half in bits 15:0.
- R3: With `split_mode`=1, a read returns the low half in bits 15:0, the prescaler in bits 23:16, and zero in bits 31:24.
- R4: In split up-count mode, each step increments the 24-bit value {prescaler, low half}. At the terminal value `load_val[23:0]` the next step gives 0.
- R5: In split down-count mode, a step with a non-zero prescaler only decrements the prescaler. A step with a zero prescaler reloads it from `pre_reload` and decrements the low half. Terminal is reached when both are zero, and a periodic reload there sets the low half to `load_val[15:0]` and the prescaler to `pre_reload`.
- R6: In wide mode, counting up goes from `load_val` to 0, and counting down goes from 0 to `load_val`. Otherwise each step moves the 32-bit count by one.
- R7: With `periodic`=1 the terminal step reloads and counting continues. With `periodic`=0 the count holds at its terminal value and `active` clears.
- R8: If `wr_en` is sampled at edge k, the written value is in the counter after edge k+1. A read strobed at edge k+1 still returns the old value.
- R9: A split-mode write loads only `wdata[15:0]`. The prescaler and upper half keep their values.
- R10: When a staged write lands in a cycle where a count step would occur, the written value wins and no step is applied.
- R11: `rdata` changes only at an edge where `rd_en` is 1. At that edge it captures the value as it stood before the edge.
- R12: `run_start` sets `active` at the next edge and `run_stop` clears it. If both are given together, `run_start` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_mode | input | 1 | 1 = 16-bit counter with 8-bit prescaler, 0 = 32-bit counter |
| count_up | input | 1 | 1 = count up, 0 = count down |
| periodic | input | 1 | 1 = periodic, 0 = one-shot |
| run_start | input | 1 | Pulse that starts counting |
| run_stop | input | 1 | Pulse that stops counting |
| pre_reload | input | 8 | Prescaler reload value for split down-count |
| load_val | input | 32 | Terminal value when counting up, reload value when counting down |
| wr_en | input | 1 | Value register write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Value register read strobe |
| rdata | output | 32 | Registered read data |
| active | output | 1 | Counter is running |

## Verification
The bench builds the block with its default widths: a 16-bit half and an 8-bit prescaler. At these widths the 24-bit split-up wrap from 0xFFFFFF to 0 is reachable in a few cycles from a loaded value. So is the 32-bit borrow across the half boundary, and so is the divide-down reload with small reload values. A cycle-accurate model in the bench steps alongside the block through every vector, including the staged write and the collision of a write with a step.

// File: rtl/tmr_val_pkg.sv
package tmr_val_pkg;

    typedef enum logic {
        WIDTH_WIDE  = 1'b0,
        WIDTH_SPLIT = 1'b1
    } width_sel_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_sel_e;

    typedef struct packed {
        width_sel_e width;
        dir_sel_e   dir;
        logic       periodic;
    } run_cfg_t;

    function automatic run_cfg_t make_cfg(input logic split, input logic up, input logic per);
        run_cfg_t c;
        c.width    = split ? WIDTH_SPLIT : WIDTH_WIDE;
        c.dir      = up ? DIR_UP : DIR_DOWN;
        c.periodic = per;
        return c;
    endfunction

endpackage

// File: rtl/tmr_wr_stage.sv
module tmr_wr_stage #(
    parameter int FULL_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [FULL_W-1:0] wdata,
    input  logic              split_in,
    output logic              pend_vld,
    output logic [FULL_W-1:0] pend_data,
    output logic              pend_split
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld   <= 1'b0;
            pend_data  <= '0;
            pend_split <= 1'b0;
        end else begin
            pend_vld   <= wr_en;
            pend_data  <= wdata;
            pend_split <= split_in;
        end
    end
endmodule

// File: rtl/tmr_step_calc.sv
module tmr_step_calc
    import tmr_val_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int PRE_W  = 8,
    localparam int FULL_W = 2 * HALF_W,
    localparam int EXT_W  = HALF_W + PRE_W
) (
    input  run_cfg_t          cfg,
    input  logic [HALF_W-1:0] lo,
    input  logic [HALF_W-1:0] hi,
    input  logic [PRE_W-1:0]  pre,
    input  logic [FULL_W-1:0] load_val,
    input  logic [PRE_W-1:0]  pre_reload,
    output logic [HALF_W-1:0] nxt_lo,
    output logic [HALF_W-1:0] nxt_hi,
    output logic [PRE_W-1:0]  nxt_pre,
    output logic              at_term
);
    logic [FULL_W-1:0] wide_cur, wide_nxt;
    logic [EXT_W-1:0]  ext_cur, ext_nxt;

    assign wide_cur = {hi, lo};
    assign ext_cur  = {pre, lo};

    always_comb begin
        nxt_lo   = lo;
        nxt_hi   = hi;
        nxt_pre  = pre;
        at_term  = 1'b0;
        wide_nxt = wide_cur;
        ext_nxt  = ext_cur;
        if (cfg.width == WIDTH_WIDE) begin
            if (cfg.dir == DIR_UP) begin
                at_term  = (wide_cur == load_val);
                wide_nxt = at_term ? (cfg.periodic ? '0 : wide_cur) : wide_cur + 1'b1;
            end else begin
                at_term  = (wide_cur == '0);
                wide_nxt = at_term ? (cfg.periodic ? load_val : wide_cur) : wide_cur - 1'b1;
            end
            nxt_hi = wide_nxt[FULL_W-1:HALF_W];
            nxt_lo = wide_nxt[HALF_W-1:0];
        end else if (cfg.dir == DIR_UP) begin
            at_term = (ext_cur == load_val[EXT_W-1:0]);
            ext_nxt = at_term ? (cfg.periodic ? '0 : ext_cur) : ext_cur + 1'b1;
            nxt_pre = ext_nxt[EXT_W-1:HALF_W];
            nxt_lo  = ext_nxt[HALF_W-1:0];
        end else begin
            at_term = (pre == '0) && (lo == '0);
            if (at_term) begin
                if (cfg.periodic) begin
                    nxt_lo  = load_val[HALF_W-1:0];
                    nxt_pre = pre_reload;
                end
            end else if (pre == '0) begin
                nxt_pre = pre_reload;
                nxt_lo  = lo - 1'b1;
            end else begin
                nxt_pre = pre - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_read_port.sv
module tmr_read_port #(
    parameter int HALF_W = 16,
    parameter int PRE_W  = 8,
    localparam int FULL_W = 2 * HALF_W,
    localparam int EXT_W  = HALF_W + PRE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              split,
    input  logic [HALF_W-1:0] lo,
    input  logic [HALF_W-1:0] hi,
    input  logic [PRE_W-1:0]  pre,
    output logic [FULL_W-1:0] rdata
);
    logic [FULL_W-1:0] word;

    assign word = split ? {{(FULL_W-EXT_W){1'b0}}, pre, lo} : {hi, lo};

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= word;
    end

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    assert_top_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && split) |=> (rdata[FULL_W-1:EXT_W] == '0));
endmodule

// File: rtl/tmr_value_reg.sv
module tmr_value_reg
    import tmr_val_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int PRE_W  = 8,
    localparam int FULL_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              split_mode,
    input  logic              count_up,
    input  logic              periodic,
    input  logic              run_start,
    input  logic              run_stop,
    input  logic [PRE_W-1:0]  pre_reload,
    input  logic [FULL_W-1:0] load_val,
    input  logic              wr_en,
    input  logic [FULL_W-1:0] wdata,
    input  logic              rd_en,
    output logic [FULL_W-1:0] rdata,
    output logic              active
);
    run_cfg_t          cfg;
    logic [HALF_W-1:0] lo_q, hi_q, lo_n, hi_n;
    logic [PRE_W-1:0]  pre_q, pre_n;
    logic              at_term;
    logic              pend_vld, pend_split;
    logic [FULL_W-1:0] pend_data;
    logic              running;

    assign cfg    = make_cfg(split_mode, count_up, periodic);
    assign active = running;

    tmr_wr_stage #(.FULL_W(FULL_W)) u_wr (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .split_in(split_mode),
        .pend_vld(pend_vld), .pend_data(pend_data), .pend_split(pend_split)
    );

    tmr_step_calc #(.HALF_W(HALF_W), .PRE_W(PRE_W)) u_step (
        .cfg(cfg), .lo(lo_q), .hi(hi_q), .pre(pre_q),
        .load_val(load_val), .pre_reload(pre_reload),
        .nxt_lo(lo_n), .nxt_hi(hi_n), .nxt_pre(pre_n), .at_term(at_term)
    );

    tmr_read_port #(.HALF_W(HALF_W), .PRE_W(PRE_W)) u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .split(split_mode),
        .lo(lo_q), .hi(hi_q), .pre(pre_q), .rdata(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q  <= '1;
            hi_q  <= '1;
            pre_q <= '1;
        end else if (pend_vld) begin
            lo_q <= pend_data[HALF_W-1:0];
            if (!pend_split) hi_q <= pend_data[FULL_W-1:HALF_W];
        end else if (running) begin
            lo_q  <= lo_n;
            hi_q  <= hi_n;
            pre_q <= pre_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                              running <= 1'b0;
        else if (run_start)                                   running <= 1'b1;
        else if (run_stop)                                    running <= 1'b0;
        else if (running && !pend_vld && at_term && !periodic) running <= 1'b0;
    end

    assert_reset_ones_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lo_q == '1 && hi_q == '1 && pre_q == '1 && !running));

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ##1 (lo_q == $past(wdata[HALF_W-1:0], 2)));

    assert_split_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (pend_vld && pend_split) |=> (pre_q == $past(pre_q) && hi_q == $past(hi_q)));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (pend_vld && running) |=> (lo_q == $past(pend_data[HALF_W-1:0])));

    assert_prescale_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (running && !pend_vld && split_mode && !count_up && pre_q != '0) |=> $stable(lo_q));

    assert_oneshot_halt_R7: assert property (@(posedge clk) disable iff (rst)
        (running && !pend_vld && at_term && !periodic && !run_start) |=> !running);

    assert_start_wins_R12: assert property (@(posedge clk) disable iff (rst)
        run_start |=> running);
endmodule

// File: tb/tmr_value_reg_test.sv
module tmr_value_reg_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {split, up, periodic, pre_reload[8], load[32], wdata[32], cycles[16]}
    localparam logic [90:0] VECS [NVEC] = '{
        {1'b0, 1'b1, 1'b1, 8'h00, 32'h0000_0010, 32'h0000_000C, 16'd10},
        {1'b0, 1'b0, 1'b1, 8'h00, 32'h0001_0002, 32'h0001_0001, 16'd5},
        {1'b0, 1'b0, 1'b0, 8'h00, 32'h0000_0005, 32'h0000_0003, 16'd8},
        {1'b1, 1'b1, 1'b1, 8'h00, 32'h00FF_FFFF, 32'h0000_FFFD, 16'd6},
        {1'b1, 1'b1, 1'b0, 8'h00, 32'h0001_0004, 32'h0000_0002, 16'd12},
        {1'b1, 1'b0, 1'b1, 8'h03, 32'h0000_0002, 32'h0000_0001, 16'd20},
        {1'b1, 1'b0, 1'b0, 8'h01, 32'h0000_0007, 32'h0000_0002, 16'd12},
        {1'b0, 1'b1, 1'b0, 8'h00, 32'h1234_5678, 32'h1234_5670, 16'd12}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        split_mode = 1'b0, count_up = 1'b0, periodic = 1'b0;
    logic        run_start = 1'b0, run_stop = 1'b0;
    logic [7:0]  pre_reload = '0;
    logic [31:0] load_val = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        active;

    int n_chk = 0, n_bad = 0, cyc = 0;

    logic [15:0] m_lo, m_hi;
    logic [7:0]  m_pre;
    logic        m_run, m_pv, m_ps;
    logic [31:0] m_pw, m_rd;

    tmr_value_reg #(.HALF_W(16), .PRE_W(8)) uut (
        .clk(clk), .rst(rst), .split_mode(split_mode), .count_up(count_up),
        .periodic(periodic), .run_start(run_start), .run_stop(run_stop),
        .pre_reload(pre_reload), .load_val(load_val), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .active(active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word(input logic split);
        return split ? {8'h00, m_pre, m_lo} : {m_hi, m_lo};
    endfunction

    task automatic tick();
        logic [15:0] n_lo = m_lo, n_hi = m_hi;
        logic [7:0]  n_pre = m_pre;
        logic        n_run = m_run;
        logic        term = 1'b0;
        logic [31:0] w = {m_hi, m_lo};
        logic [23:0] e = {m_pre, m_lo};
        if (rd_en) m_rd = model_word(split_mode);
        if (m_pv) begin
            n_lo = m_pw[15:0];
            if (!m_ps) n_hi = m_pw[31:16];
        end else if (m_run) begin
            if (!split_mode) begin
                term = count_up ? (w == load_val) : (w == 0);
                if (!term) w = count_up ? w + 1 : w - 1;
                else if (periodic) w = count_up ? 32'h0 : load_val;
                {n_hi, n_lo} = w;
            end else if (count_up) begin
                term = (e == load_val[23:0]);
                if (!term) e = e + 1;
                else if (periodic) e = 24'h0;
                {n_pre, n_lo} = e;
            end else begin
                term = (m_pre == 0) && (m_lo == 0);
                if (term) begin
                    if (periodic) begin n_lo = load_val[15:0]; n_pre = pre_reload; end
                end else if (m_pre == 0) begin
                    n_pre = pre_reload; n_lo = m_lo - 1;
                end else n_pre = m_pre - 1;
            end
        end
        if (run_start) n_run = 1'b1;
        else if (run_stop) n_run = 1'b0;
        else if (m_run && !m_pv && term && !periodic) n_run = 1'b0;
        @(posedge clk);
        m_lo = n_lo; m_hi = n_hi; m_pre = n_pre; m_run = n_run;
        m_pv = wr_en; m_pw = wdata; m_ps = split_mode;
        @(negedge clk);
    endtask

    task automatic do_read();
        rd_en = 1'b1; tick(); rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [31:0] v);
        wr_en = 1'b1; wdata = v; tick(); wr_en = 1'b0;
    endtask

    initial begin
        m_lo = '1; m_hi = '1; m_pre = '1; m_run = 0; m_pv = 0; m_ps = 0; m_pw = 0; m_rd = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R2 reset state, wide read
        check("R1 active after reset", {31'b0, active}, 32'h0);
        do_read();
        check("R1 R2 wide read after reset", rdata, 32'hFFFF_FFFF);
        // R3 split read layout
        split_mode = 1'b1; do_read();
        check("R3 split read after reset", rdata, 32'h00FF_FFFF);

        // R8 write latency
        split_mode = 1'b0;
        do_write(32'hA5A5_0F0F);
        do_read();
        check("R8 read right after write is old", rdata, 32'hFFFF_FFFF);
        do_read();
        check("R8 written value landed", rdata, 32'hA5A5_0F0F);

        // R9 split write touches low half only
        split_mode = 1'b1;
        do_write(32'h7777_8888);
        tick();
        do_read();
        check("R9 split read after split write", rdata, 32'h00FF_8888);
        split_mode = 1'b0; do_read();
        check("R9 upper half kept", rdata, 32'hA5A5_8888);

        // R11 rdata holds without strobe
        do_write(32'h0000_1111);
        repeat (3) tick();
        check("R11 rdata held", rdata, 32'hA5A5_8888);

        // R12 start beats stop
        run_start = 1'b1; run_stop = 1'b1; tick(); run_start = 1'b0;
        check("R12 start wins", {31'b0, active}, 32'h1);
        tick(); run_stop = 1'b0;
        check("R12 stop clears", {31'b0, active}, 32'h0);

        // R10 write collides with a count step
        count_up = 1'b0; periodic = 1'b1; load_val = 32'd100;
        do_write(32'd50); tick();
        run_start = 1'b1; tick(); run_start = 1'b0;
        tick(); tick();
        do_write(32'h0000_0200);
        run_stop = 1'b1; tick(); run_stop = 1'b0;
        do_read();
        check("R10 write wins over step", rdata, 32'h0000_0200);

        // R7 one-shot wide down stops at zero
        periodic = 1'b0;
        do_write(32'd2); tick();
        run_start = 1'b1; tick(); run_start = 1'b0;
        repeat (6) tick();
        do_read();
        check("R7 one-shot holds at zero", rdata, 32'h0);
        check("R7 one-shot clears active", {31'b0, active}, 32'h0);

        // Vector table: R2 R3 R4 R5 R6 R7 against the model
        for (int i = 0; i < NVEC; i++) begin
            logic [90:0] v = VECS[i];
            split_mode = v[90]; count_up = v[89]; periodic = v[88];
            pre_reload = v[87:80]; load_val = v[79:48];
            run_stop = 1'b1; tick(); run_stop = 1'b0;
            do_write(v[47:16]); tick();
            run_start = 1'b1; tick(); run_start = 1'b0;
            for (int c = 0; c < int'(v[15:0]); c++) tick();
            do_read();
            check(v[90] ? (v[89] ? "R4 R3 split up vector" : "R5 R3 split down vector")
                        : "R6 R2 wide vector", rdata, m_rd);
            check("R7 active vs model", {31'b0, active}, {31'b0, m_run});
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule